// File: doc/BRIEF.md
# Count/Compare Timer with Interrupt Acceptance Gate

This block holds the free-running cycle counter, its comparison register and the interrupt-acceptance decision of a system control coprocessor. Each time the cycle strobe is high, the counter steps by one. When the stepped value equals the comparison register, a sticky timer request is raised in the Cause pending field. On that same strobe the block decides whether the processor takes an interrupt. Stalled cycles in the wait state still strobe the block.

An interrupt is taken only under three conditions together: the global enable is set, both the exception-level and error-level flags are clear, and a pending request in the hardware field overlaps its mask bit. When one is taken, the block emits a one-cycle pulse, leaves the wait state and writes the interrupt exception code into Cause. Vectoring and the return-address update belong to the surrounding core.

Top module: `cp_timer_irq_gate`

## Requirements
- R1: On every clock edge with `cyc_en`=1 and no count write, `count_o` becomes its previous value plus one, wrapping from 0xFFFFFFFF to 0 without setting any Cause bit.
- R2: `wr_count` loads `count_wdata` into the counter and takes priority over the increment in the same cycle.
- R3: When the incremented count equals the compare value, Cause bit 15 is set at that edge and stays set until cleared.
- R4: A write to the compare register (`wr_compare`) clears Cause bit 15.
- R5: An interrupt is taken only when Status bit 0 (enable) is 1, Status bit 1 (exception level) is 0 and Status bit 2 (error level) is 0.
- R6: An interrupt is taken only when (Cause AND Status AND 0xFC00) is nonzero. The Status mask sits in bits 15:8, and the software pending bits 9:8 never cause an interrupt.
- R7: `slave_irq` is captured into Cause bit 10 only on strobed cycles where R5's enable condition holds. On other cycles, bit 10 keeps its value.
- R8: Taking an interrupt raises `take_o` for one cycle after the deciding edge, clears `wait_o` and writes exception code 0 into Cause bits 6:2.
- R9: The external lines `hw_irq[3:0]` appear level-sensitive in Cause bits 14:11.
- R10: With `cyc_en`=0, the counter holds and no interrupt is taken.
- R11: `wr_cause` writes software pending bits 9:8 and the exception field 6:2. `wait_req` sets `wait_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | One executed (or waiting) processor cycle |
| wr_count | input | 1 | Counter write strobe |
| count_wdata | input | 32 | Counter write data |
| wr_compare | input | 1 | Compare write strobe |
| compare_wdata | input | 32 | Compare write data |
| wr_status | input | 1 | Status write strobe |
| status_wdata | input | 16 | Status: 0 enable, 1 exception level, 2 error level, 15:8 mask |
| wr_cause | input | 1 | Cause write strobe |
| cause_wdata | input | 32 | Cause data: bits 9:8 software pending, 6:2 exception code |
| wait_req | input | 1 | Enter the wait state |
| hw_irq | input | 4 | External interrupt lines to Cause 14:11 |
| slave_irq | input | 1 | Secondary controller request, sampled into Cause 10 |
| count_o | output | 32 | Current counter value |
| cause_o | output | 32 | Cause view: 15:8 pending, 6:2 exception code |
| take_o | output | 1 | Interrupt-taken pulse |
| wait_o | output | 1 | Wait-state flag |

## Verification
On every cycle, the assertions check the counter step and load, that a compare write clears the timer request, that the timer request stays set, that no interrupt is taken without a strobe or without the enable condition, and that a take clears the wait state and the exception field. Only the bench scenarios can show the following: the mask overlap selects the right sources, the software bits are excluded, the slave line is sampled only while enabled, and a timer match under the exception level stays pending and is taken once that level drops.

// File: rtl/cpt_pkg.sv
// Package: bit positions of the Status and Cause fields used by the timer/gate.
// Assumes the architectural layout: pending field 15:8, hardware part 15:10.
package cpt_pkg;
    localparam int CNT_W     = 32;
    localparam int ST_W      = 16;
    localparam int IE_BIT    = 0;
    localparam int EXL_BIT   = 1;
    localparam int ERL_BIT   = 2;
    localparam int HWF_LO    = 10;
    localparam int HWF_HI    = 15;
    localparam int HWF_W     = HWF_HI - HWF_LO + 1;
    localparam int EXT_LINES = HWF_W - 2;
    localparam int EXC_LO    = 2;
    localparam int EXC_W     = 5;
    localparam logic [EXC_W-1:0] EXC_INT = 5'd0;
endpackage

// File: rtl/cpt_counter.sv
// Module: counter/compare pair with sticky timer request.
// Assumes cyc_en marks one processor cycle; a count write wins over the step.
module cpt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_en,
    input  logic         wr_count,
    input  logic [W-1:0] count_wdata,
    input  logic         wr_compare,
    input  logic [W-1:0] compare_wdata,
    output logic [W-1:0] count_o,
    output logic         match_o,
    output logic         ti_o
);
    logic [W-1:0] count_q;
    logic [W-1:0] compare_q;
    logic [W-1:0] count_inc;
    logic         ti_q;

    // Incremented value and the equality test on it.
    always_comb begin
        count_inc = count_q + 1'b1;
        match_o   = cyc_en && !wr_count && (count_inc == compare_q);
    end

    // Counter register: load, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (wr_count)   count_q <= count_wdata;
        else if (cyc_en)     count_q <= count_inc;
    end

    // Compare register, reset to all ones so a fresh count does not match soon.
    always_ff @(posedge clk) begin
        if (!rst_n)          compare_q <= '1;
        else if (wr_compare) compare_q <= compare_wdata;
    end

    // Sticky timer request; a compare write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)          ti_q <= 1'b0;
        else if (wr_compare) ti_q <= 1'b0;
        else if (match_o)    ti_q <= 1'b1;
    end

    assign count_o = count_q;
    assign ti_o    = ti_q;
endmodule

// File: rtl/cpt_irq_gate.sv
// Module: enable check, slave sampling and mask overlap that decide a take.
// Assumes Status bits are already registered; the take decision is combinational.
module cpt_irq_gate
    import cpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_en,
    input  logic [ST_W-1:0]      status,
    input  logic                 ti_eff,
    input  logic [EXT_LINES-1:0] hw_irq,
    input  logic                 slave_irq,
    output logic                 slave_o,
    output logic                 take_d
);
    logic              enabled;
    logic [HWF_W-1:0]  pend;
    logic              slave_q;

    // Enable condition and pending/mask overlap of the hardware field.
    always_comb begin
        enabled = status[IE_BIT] && !status[EXL_BIT] && !status[ERL_BIT];
        pend    = {ti_eff, hw_irq, slave_irq};
        take_d  = cyc_en && enabled && (|(pend & status[HWF_HI:HWF_LO]));
    end

    // Slave line is captured only on enabled strobed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                 slave_q <= 1'b0;
        else if (cyc_en && enabled) slave_q <= slave_irq;
    end

    assign slave_o = slave_q;
endmodule

// File: rtl/cp_timer_irq_gate.sv
// Module: top of the timer and interrupt gate; holds Status, Cause soft bits,
// exception code and wait flag. Assumes one strobe per processor cycle.
module cp_timer_irq_gate
    import cpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_en,
    input  logic                 wr_count,
    input  logic [CNT_W-1:0]     count_wdata,
    input  logic                 wr_compare,
    input  logic [CNT_W-1:0]     compare_wdata,
    input  logic                 wr_status,
    input  logic [ST_W-1:0]      status_wdata,
    input  logic                 wr_cause,
    input  logic [31:0]          cause_wdata,
    input  logic                 wait_req,
    input  logic [EXT_LINES-1:0] hw_irq,
    input  logic                 slave_irq,
    output logic [CNT_W-1:0]     count_o,
    output logic [31:0]          cause_o,
    output logic                 take_o,
    output logic                 wait_o
);
    logic [ST_W-1:0]  status_q;
    logic [1:0]       sw_q;
    logic [EXC_W-1:0] exc_q;
    logic             wait_q;
    logic             take_q;
    logic             match;
    logic             ti_q;
    logic             slave_q;
    logic             take_d;

    cpt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
        .wr_count(wr_count), .count_wdata(count_wdata),
        .wr_compare(wr_compare), .compare_wdata(compare_wdata),
        .count_o(count_o), .match_o(match), .ti_o(ti_q)
    );

    cpt_irq_gate u_gate (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .status(status_q),
        .ti_eff(ti_q || match), .hw_irq(hw_irq), .slave_irq(slave_irq),
        .slave_o(slave_q), .take_d(take_d)
    );

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n)         status_q <= '0;
        else if (wr_status) status_q <= status_wdata;
    end

    // Software pending bits and exception code; a take records the interrupt code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q  <= '0;
            exc_q <= '0;
        end else begin
            if (wr_cause) begin
                sw_q  <= cause_wdata[9:8];
                exc_q <= cause_wdata[EXC_LO+EXC_W-1:EXC_LO];
            end
            if (take_d) exc_q <= EXC_INT;
        end
    end

    // Wait flag: a take leaves the wait state, else a request enters it.
    always_ff @(posedge clk) begin
        if (!rst_n)        wait_q <= 1'b0;
        else if (take_d)   wait_q <= 1'b0;
        else if (wait_req) wait_q <= 1'b1;
    end

    // One-cycle take pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) take_q <= 1'b0;
        else        take_q <= take_d;
    end

    // Cause view assembled from its owners.
    always_comb begin
        cause_o                          = '0;
        cause_o[15]                      = ti_q;
        cause_o[14:11]                   = hw_irq;
        cause_o[10]                      = slave_q;
        cause_o[9:8]                     = sw_q;
        cause_o[EXC_LO+EXC_W-1:EXC_LO]   = exc_q;
    end

    assign take_o = take_q;
    assign wait_o = wait_q;
endmodule

// File: rtl/cpt_checker.sv
// Module: temporal checks for cp_timer_irq_gate, attached by bind below.
module cpt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cyc_en,
    input logic        wr_count,
    input logic [31:0] count_wdata,
    input logic        wr_compare,
    input logic [15:0] status_q,
    input logic [31:0] count_o,
    input logic [31:0] cause_o,
    input logic        take_o,
    input logic        wait_o
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !wr_count) |=> count_o == $past(count_o) + 32'd1); // R1
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> count_o == $past(count_wdata)); // R2
    AST_TI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o[15] && !wr_compare) |=> cause_o[15]); // R3
    AST_CMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_compare |=> !cause_o[15]); // R4
    AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(status_q[0] && !status_q[1] && !status_q[2])); // R5
    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (!wait_o && cause_o[6:2] == 5'd0)); // R8
    AST_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> !take_o); // R10
endmodule

bind cp_timer_irq_gate cpt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_count(wr_count),
    .count_wdata(count_wdata), .wr_compare(wr_compare), .status_q(status_q),
    .count_o(count_o), .cause_o(cause_o), .take_o(take_o), .wait_o(wait_o)
);

// File: tb/cp_timer_irq_gate_bench.sv
`timescale 1ns/1ps
module cp_timer_irq_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b0;
    logic        wr_count = 1'b0;
    logic [31:0] count_wdata = '0;
    logic        wr_compare = 1'b0;
    logic [31:0] compare_wdata = '0;
    logic        wr_status = 1'b0;
    logic [15:0] status_wdata = '0;
    logic        wr_cause = 1'b0;
    logic [31:0] cause_wdata = '0;
    logic        wait_req = 1'b0;
    logic [3:0]  hw_irq = '0;
    logic        slave_irq = 1'b0;
    logic [31:0] count_o;
    logic [31:0] cause_o;
    logic        take_o;
    logic        wait_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cp_timer_irq_gate u_cp_timer_irq_gate (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en),
        .wr_count(wr_count), .count_wdata(count_wdata),
        .wr_compare(wr_compare), .compare_wdata(compare_wdata),
        .wr_status(wr_status), .status_wdata(status_wdata),
        .wr_cause(wr_cause), .cause_wdata(cause_wdata),
        .wait_req(wait_req), .hw_irq(hw_irq), .slave_irq(slave_irq),
        .count_o(count_o), .cause_o(cause_o), .take_o(take_o), .wait_o(wait_o)
    );

    // Vector: {status[15:0], hw[3:0], slave, expected take}
    localparam logic [21:0] VEC [8] = '{
        {16'h0401, 4'b0000, 1'b1, 1'b1},
        {16'h0403, 4'b0000, 1'b1, 1'b0},
        {16'h0405, 4'b0000, 1'b1, 1'b0},
        {16'h0400, 4'b0000, 1'b1, 1'b0},
        {16'h0801, 4'b0001, 1'b0, 1'b1},
        {16'h0801, 4'b0010, 1'b0, 1'b0},
        {16'h7801, 4'b1000, 1'b0, 1'b1},
        {16'h0001, 4'b1111, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge; outputs are then read at the negedge; strobes drop.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cyc_en = 1'b0; wr_count = 1'b0; wr_compare = 1'b0;
        wr_status = 1'b0; wr_cause = 1'b0; wait_req = 1'b0;
    endtask

    task automatic set_status(input logic [15:0] v);
        wr_status = 1'b1; status_wdata = v; step();
    endtask
    task automatic set_count(input logic [31:0] v);
        wr_count = 1'b1; count_wdata = v; step();
    endtask
    task automatic set_compare(input logic [31:0] v);
        wr_compare = 1'b1; compare_wdata = v; step();
    endtask
    task automatic set_cause(input logic [31:0] v);
        wr_cause = 1'b1; cause_wdata = v; step();
    endtask
    task automatic cycle();
        cyc_en = 1'b1; step();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        check("R10 reset count", count_o, 32'd0);
        check("R8 reset cause", cause_o, 32'd0);
        check("R8 reset take", {31'd0, take_o}, 32'd0);
        check("R11 reset wait", {31'd0, wait_o}, 32'd0);

        // Vector table: R5/R6/R7 gate decisions
        for (int i = 0; i < 8; i++) begin
            set_status(VEC[i][21:6]);
            hw_irq = VEC[i][5:2];
            slave_irq = VEC[i][1];
            cycle();
            check($sformatf("R5/R6 vec%0d take", i), {31'd0, take_o}, {31'd0, VEC[i][0]});
        end
        hw_irq = '0; slave_irq = 1'b0;

        // R6: software pending bits do not cause a take
        set_cause(32'h0000_0300);
        check("R11 sw bits", {30'd0, cause_o[9:8]}, 32'd3);
        set_status(16'h0301);
        cycle();
        check("R6 sw ignored", {31'd0, take_o}, 32'd0);

        // R7: slave sampling only while enabled
        set_status(16'h0001); slave_irq = 1'b0; cycle();
        check("R7 sampled low", {31'd0, cause_o[10]}, 32'd0);
        set_status(16'h0003); slave_irq = 1'b1; cycle();
        check("R7 held under EXL", {31'd0, cause_o[10]}, 32'd0);
        set_status(16'h0001); cycle();
        check("R7 sampled high", {31'd0, cause_o[10]}, 32'd1);
        slave_irq = 1'b0;

        // R9: external lines visible
        hw_irq = 4'b1010; #1;
        check("R9 hw lines", {28'd0, cause_o[14:11]}, 32'h0000_000A);
        hw_irq = '0;

        // R1/R2: load, step, wrap with no Cause side effect
        set_status(16'h0000);
        set_compare(32'h100);
        set_count(32'hFFFF_FFFE);
        check("R2 load", count_o, 32'hFFFF_FFFE);
        cycle();
        check("R1 step", count_o, 32'hFFFF_FFFF);
        cycle();
        check("R1 wrap", count_o, 32'd0);
        check("R1 no timer bit", {31'd0, cause_o[15]}, 32'd0);
        wr_count = 1'b1; count_wdata = 32'h55; cyc_en = 1'b1; step();
        check("R2 write wins", count_o, 32'h55);

        // R10: no strobe, count holds
        step();
        check("R10 hold", count_o, 32'h55);

        // R3: match after increment, sticky
        set_compare(32'h10);
        set_count(32'h0E);
        cycle();
        check("R3 no early match", {31'd0, cause_o[15]}, 32'd0);
        cycle();
        check("R3 match sets", {31'd0, cause_o[15]}, 32'd1);
        cycle();
        check("R3 sticky", {31'd0, cause_o[15]}, 32'd1);

        // R4: compare write clears
        set_compare(32'h1000);
        check("R4 compare clears", {31'd0, cause_o[15]}, 32'd0);

        // R5: EXL blocks a timer match, taken once EXL drops
        set_compare(32'd5);
        set_count(32'd4);
        set_status(16'h8003);
        cycle();
        check("R3 match under EXL", {31'd0, cause_o[15]}, 32'd1);
        check("R5 EXL blocks", {31'd0, take_o}, 32'd0);
        set_cause(32'h0000_0028);
        wait_req = 1'b1; step();
        check("R11 wait set", {31'd0, wait_o}, 32'd1);
        check("R11 exc written", {27'd0, cause_o[6:2]}, 32'h0A);
        set_status(16'h8001);
        cycle();
        check("R8 take", {31'd0, take_o}, 32'd1);
        check("R8 wait cleared", {31'd0, wait_o}, 32'd0);
        check("R8 exc code", {27'd0, cause_o[6:2]}, 32'd0);
        step();
        check("R10 pulse ends", {31'd0, take_o}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule